// File: doc/BRIEF.md
# PWM Timebase with Fractional Divider

This block is the time reference for a PWM generator. A selected source enable (a slow clock enable or a reference tick enable, both in the same clock domain as the block) feeds a fractional divider. The divisor is a fixed-point number with eight fractional bits, so the divider can produce non-integer division ratios on average. Each divider output tick advances a counter whose range is a power of two chosen by a resolution field. Downstream duty comparators read the counter value and use the overflow pulse to mark the start of each PWM period.

Software controls the block through one configuration word. It holds the divisor, the resolution, a pause bit, a timer reset bit, a source select bit and an update strobe. The divisor and resolution that the datapath uses are shadow copies. They load only when a write sets the update strobe, so software can prepare new values without disturbing a running period. The timer reset bit is set after chip reset, so the timer starts cleared and idle.

Top module: `pwm_timebase`

## Requirements
- R1: After chip reset `cfg_rdata` reads 0x0100_0000, `count` is 0 and `overflow` is 0.
- R2: The word layout is: resolution in bits 4:0, divisor in bits 22:5 (the low 8 divisor bits are fractional), pause in bit 23, timer reset in bit 24, source select in bit 25 and update strobe in bit 26. A write stores bits 25:0 and `cfg_rdata` returns them on the cycle after the write edge. Bits 31:27 of `cfg_wdata` are dropped and read back as 0.
- R3: The update strobe (bit 26) is never stored, so `cfg_rdata[26]` is always 0.
- R4: The active divisor and resolution change only on a write with bit 26 set, and they take that write's values. A write with bit 26 clear leaves them unchanged.
- R5: Each selected source enable adds 256 to an accumulator. When the sum is at least the active divisor, one counter tick is issued and the divisor is subtracted. A divisor below 256 behaves as 256.
- R6: Source select 0 uses `slow_tick` and 1 uses `ref_tick`. The unselected input has no effect.
- R7: The counter runs from 0 to 2^res − 1 and then wraps to 0. A resolution of CNT_W or more uses the full counter width.
- R8: `overflow` is high for the one cycle in which `count` has just wrapped from its maximum to 0.
- R9: While pause is 1, `count` does not change.
- R10: While the timer reset bit is stored as 1, `count` reads 0 from the cycle after the write edge. The reset also clears the counter and the divider accumulator, so a restart does not depend on any earlier fractional remainder.
- R11: A source enable sampled at one clock edge changes `count` at the second edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous chip reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Stored configuration readback |
| slow_tick | input | 1 | Slow clock enable (source 0) |
| ref_tick | input | 1 | Reference tick enable (source 1) |
| count | output | CNT_W | Current counter value |
| overflow | output | 1 | One-cycle pulse on counter wrap |

## Verification
Configuration readback and the reset masking of `count` become visible one edge after the write. The divider tick is registered and the counter is registered behind it, so a source enable shows up in `count` two edges later. `overflow` rises on the same edge as the wrap to 0. The bench drives inputs and samples at the falling edge. After each write it waits out that edge, and after the last source pulse of a sequence it waits several cycles before it compares the count or the number of overflow pulses. One directed check samples `count` after one edge and again after two, to confirm the latency exactly.

// File: rtl/ptb_pkg.sv
`timescale 1ns/1ps
package ptb_pkg;
   // word layout; the bit positions are decoded by software, so they are fixed
   localparam int RES_LSB   = 0;
   localparam int RES_W     = 5;
   localparam int DIV_LSB   = 5;
   localparam int DIV_W     = 18;
   localparam int DIV_FRAC  = 8;
   localparam int PAUSE_BIT = 23;
   localparam int CLR_BIT   = 24;
   localparam int SEL_BIT   = 25;
   localparam int UPD_BIT   = 26;
   localparam int CFG_W     = 32;
   localparam int STORE_W   = UPD_BIT;   // bits kept in the register
   localparam logic [CFG_W-1:0] CFG_RESET = 32'h0100_0000;

   typedef enum logic {SRC_SLOW = 1'b0, SRC_REF = 1'b1} src_e;

   typedef struct packed {
      logic sel;
      logic hold;
      logic clr;
   } ctl_t;

   typedef struct packed {
      logic [DIV_W-1:0] div;
      logic [RES_W-1:0] res;
   } act_t;
endpackage

// File: rtl/ptb_cfg.sv
`timescale 1ns/1ps
module ptb_cfg
   import ptb_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CFG_W-1:0] wdata,
   output logic [CFG_W-1:0] rdata,
   output ctl_t             ctl,
   output act_t             act
);
   logic [STORE_W-1:0] stored_q;
   act_t               act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stored_q <= CFG_RESET[STORE_W-1:0];
         act_q    <= '0;
      end else if (we) begin
         stored_q <= wdata[STORE_W-1:0];
         if (wdata[UPD_BIT]) begin
            act_q.div <= wdata[DIV_LSB +: DIV_W];
            act_q.res <= wdata[RES_LSB +: RES_W];
         end
      end
   end

   // wdata[31:27] are dropped and the strobe is not stored, so they are unused
   logic unused_hi;
   assign unused_hi = ^wdata[CFG_W-1:UPD_BIT];

   assign rdata    = {{(CFG_W-STORE_W){1'b0}}, stored_q};
   assign ctl.sel  = stored_q[SEL_BIT];
   assign ctl.hold = stored_q[PAUSE_BIT];
   assign ctl.clr  = stored_q[CLR_BIT];
   assign act      = act_q;
endmodule

// File: rtl/ptb_fracdiv.sv
`timescale 1ns/1ps
module ptb_fracdiv #(
   parameter int DIV_W  = 18,
   parameter int FRAC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             src_tick,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   localparam int ACC_W = DIV_W + 1;
   localparam logic [ACC_W-1:0] ONE = ACC_W'(1) << FRAC_W;

   if (FRAC_W < 1 || FRAC_W >= DIV_W) begin : g_bad_frac
      $error("ptb_fracdiv: FRAC_W must lie in 1..DIV_W-1");
   end

   logic [ACC_W-1:0] acc_q, div_ext, div_eff, sum;
   logic             hit;

   assign div_ext = {1'b0, div};
   assign div_eff = (div_ext < ONE) ? ONE : div_ext;
   assign sum     = acc_q + ONE;
   assign hit     = (sum >= div_eff);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         tick  <= 1'b0;
      end else if (clr) begin
         acc_q <= '0;
         tick  <= 1'b0;
      end else begin
         tick <= src_tick & hit;
         if (src_tick) acc_q <= hit ? (sum - div_eff) : sum;
      end
   end
endmodule

// File: rtl/ptb_counter.sv
`timescale 1ns/1ps
module ptb_counter #(
   parameter int CNT_W = 16,
   parameter int RES_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             hold,
   input  logic             tick,
   input  logic [RES_W-1:0] res,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);
   logic [CNT_W-1:0] lim;
   logic             at_top;

   // bit i of the limit is set when i < res; res >= CNT_W fills the width
   for (genvar i = 0; i < CNT_W; i++) begin : g_lim
      assign lim[i] = (32'(res) > i);
   end

   assign at_top = (cnt >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         wrap <= 1'b0;
      end else if (clr) begin
         cnt  <= '0;
         wrap <= 1'b0;
      end else if (tick && !hold) begin
         cnt  <= at_top ? '0 : cnt + 1'b1;
         wrap <= at_top;
      end else begin
         wrap <= 1'b0;
      end
   end
endmodule

// File: rtl/pwm_timebase.sv
`timescale 1ns/1ps
module pwm_timebase
   import ptb_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [31:0]      cfg_wdata,
   output logic [31:0]      cfg_rdata,
   input  logic             slow_tick,
   input  logic             ref_tick,
   output logic [CNT_W-1:0] count,
   output logic             overflow
);
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
      $error("pwm_timebase: CNT_W must lie in 1..32");
   end

   ctl_t             ctl;
   act_t             act;
   logic             src_tick;
   logic             div_tick;
   logic [CNT_W-1:0] cnt_q;
   logic             wrap_q;

   ptb_cfg u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .wdata (cfg_wdata),
      .rdata (cfg_rdata),
      .ctl   (ctl),
      .act   (act)
   );

   assign src_tick = (src_e'(ctl.sel) == SRC_REF) ? ref_tick : slow_tick;

   ptb_fracdiv #(.DIV_W(DIV_W), .FRAC_W(DIV_FRAC)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (ctl.clr),
      .src_tick (src_tick),
      .div      (act.div),
      .tick     (div_tick)
   );

   ptb_counter #(.CNT_W(CNT_W), .RES_W(RES_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (ctl.clr),
      .hold  (ctl.hold),
      .tick  (div_tick),
      .res   (act.res),
      .cnt   (cnt_q),
      .wrap  (wrap_q)
   );

   assign count    = ctl.clr ? '0 : cnt_q;
   assign overflow = wrap_q;
endmodule

// File: rtl/ptb_checker.sv
`timescale 1ns/1ps
module ptb_checker #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_we,
   input logic             pause_q,
   input logic             clr_q,
   input logic             upd_q,
   input logic             div_tick,
   input logic [CNT_W-1:0] count,
   input logic             overflow
);
   // R3
   p_upd_never_stored_r3: assert property (@(posedge clk) disable iff (!rst_n)
      upd_q == 1'b0);

   // R10
   p_clear_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      clr_q |-> (count == '0));

   // R9
   p_pause_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pause_q && !clr_q && !cfg_we) |=> $stable(count));

   // R8
   p_wrap_lands_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |-> (count == '0));

   // R11
   p_moves_only_on_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!div_tick && !cfg_we && !clr_q) |=> $stable(count));
endmodule

bind pwm_timebase ptb_checker #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cfg_we   (cfg_we),
   .pause_q  (cfg_rdata[23]),
   .clr_q    (cfg_rdata[24]),
   .upd_q    (cfg_rdata[26]),
   .div_tick (div_tick),
   .count    (count),
   .overflow (overflow)
);

// File: tb/tb_pwm_timebase.sv
`timescale 1ns/1ps
module tb_pwm_timebase;
   localparam int CNT_W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_we = 1'b0;
   logic [31:0]      cfg_wdata = '0;
   logic [31:0]      cfg_rdata;
   logic             slow_tick = 1'b0;
   logic             ref_tick = 1'b0;
   logic [CNT_W-1:0] count;
   logic             overflow;

   int errors = 0;
   int checks = 0;
   int ovf_total = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pwm_timebase #(.CNT_W(CNT_W)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .slow_tick(slow_tick), .ref_tick(ref_tick),
      .count(count), .overflow(overflow)
   );

   always @(negedge clk) if (rst_n && overflow) ovf_total++;

   // {div[17:0], res[4:0], sel, n_src[7:0], exp_count[15:0], exp_ovf[7:0]}
   localparam int NV = 8;
   localparam logic [55:0] VEC [NV] = '{
      {18'd256, 5'd3, 1'b0, 8'd5,  16'd5, 8'd0},  // integer 1.0
      {18'd256, 5'd2, 1'b0, 8'd10, 16'd2, 8'd2},  // wraps twice
      {18'd384, 5'd4, 1'b0, 8'd6,  16'd4, 8'd0},  // 1.5
      {18'd512, 5'd1, 1'b0, 8'd9,  16'd0, 8'd2},  // 2.0
      {18'd100, 5'd3, 1'b0, 8'd3,  16'd3, 8'd0},  // below 256 -> 1.0
      {18'd0,   5'd0, 1'b0, 8'd3,  16'd0, 8'd3},  // range of one value
      {18'd640, 5'd5, 1'b1, 8'd10, 16'd4, 8'd0},  // 2.5, reference source
      {18'd768, 5'd2, 1'b1, 8'd12, 16'd0, 8'd1}   // 3.0, reference source
   };

   function automatic logic [31:0] mk(input logic [17:0] dv, input logic [4:0] rs,
                                      input logic ps, input logic cl,
                                      input logic sl, input logic up);
      return {5'd0, up, sl, cl, ps, dv, rs};
   endfunction

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [31:0] w);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_wdata = w;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic drive(input logic s, input logic r);
      @(negedge clk);
      slow_tick = s;
      ref_tick = r;
   endtask

   // one selected pulse, then one pulse on the unselected line
   task automatic pulse(input logic sel, input int n);
      for (int k = 0; k < n; k++) begin
         drive(!sel, sel);
         drive(sel, !sel);
      end
      drive(1'b0, 1'b0);
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   initial begin
      #(10 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] w;
      int base;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 readback", cfg_rdata, 32'h0100_0000);
      check("R1 count", 32'(count), 32'd0);
      check("R1 overflow", 32'(overflow), 32'd0);

      // R2 / R3 layout and strobe
      w = mk(18'h2A5A5, 5'h13, 1'b1, 1'b1, 1'b1, 1'b1) | 32'hF800_0000;
      wr(w);
      check("R2 readback", cfg_rdata, w & 32'h03FF_FFFF);
      check("R3 strobe bit", 32'(cfg_rdata[26]), 32'd0);

      // vector table: R5 R6 R7 R8
      for (int v = 0; v < NV; v++) begin
         logic [17:0] dv; logic [4:0] rs; logic sl; logic [7:0] n;
         logic [15:0] ec; logic [7:0] eo;
         {dv, rs, sl, n, ec, eo} = VEC[v];
         wr(mk(dv, rs, 1'b0, 1'b1, sl, 1'b1));
         wr(mk(dv, rs, 1'b0, 1'b0, sl, 1'b0));
         base = ovf_total;
         pulse(sl, int'(n));
         settle();
         check($sformatf("R5 R6 R7 vec%0d count", v), 32'(count), 32'(ec));
         check($sformatf("R8 vec%0d overflows", v), 32'(ovf_total - base), 32'(eo));
      end

      // R4 shadowing
      wr(mk(18'd256, 5'd2, 1'b0, 1'b1, 1'b0, 1'b1));
      wr(mk(18'd256, 5'd2, 1'b0, 1'b0, 1'b0, 1'b0));
      wr(mk(18'd256, 5'd4, 1'b0, 1'b0, 1'b0, 1'b0));
      pulse(1'b0, 5);
      settle();
      check("R4 res unchanged without strobe", 32'(count), 32'd1);
      wr(mk(18'd256, 5'd4, 1'b0, 1'b0, 1'b0, 1'b1));
      pulse(1'b0, 5);
      settle();
      check("R4 res loaded by strobe", 32'(count), 32'd6);

      // R9 pause
      wr(mk(18'd256, 5'd4, 1'b1, 1'b0, 1'b0, 1'b0));
      pulse(1'b0, 3);
      settle();
      check("R9 paused count", 32'(count), 32'd6);
      wr(mk(18'd256, 5'd4, 1'b0, 1'b0, 1'b0, 1'b0));
      pulse(1'b0, 1);
      settle();
      check("R9 resumed count", 32'(count), 32'd7);

      // R11 latency
      drive(1'b1, 1'b0);
      drive(1'b0, 1'b0);
      check("R11 one edge later", 32'(count), 32'd7);
      @(negedge clk);
      check("R11 two edges later", 32'(count), 32'd8);

      // R10 reset masking and accumulator clear
      wr(mk(18'd256, 5'd4, 1'b0, 1'b1, 1'b0, 1'b0));
      check("R10 count masked", 32'(count), 32'd0);
      wr(mk(18'd512, 5'd4, 1'b0, 1'b1, 1'b0, 1'b1));
      wr(mk(18'd512, 5'd4, 1'b0, 1'b0, 1'b0, 1'b0));
      pulse(1'b0, 1);
      settle();
      check("R10 half step", 32'(count), 32'd0);
      wr(mk(18'd512, 5'd4, 1'b0, 1'b1, 1'b0, 1'b0));
      wr(mk(18'd512, 5'd4, 1'b0, 1'b0, 1'b0, 1'b0));
      pulse(1'b0, 1);
      settle();
      check("R10 accumulator cleared", 32'(count), 32'd0);
      pulse(1'b0, 1);
      settle();
      check("R10 tick after restart", 32'(count), 32'd1);

      // R6 unselected source alone
      repeat (3) begin
         drive(1'b0, 1'b1);
         drive(1'b0, 1'b0);
      end
      settle();
      check("R6 unselected ignored", 32'(count), 32'd1);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule